// File: doc/BRIEF.md
# Four-Lane SD Read-Block Receiver

This block takes read data from a card on a four-line SD data bus and turns it into bytes. The host supplies a one-cycle sample strobe for each bus clock edge on which the four data lines hold a valid value. The bus clock may stop at any time, so the receiver changes state only on a strobe. While searching, the receiver waits for a strobe that sees all four lines low. It then takes 1024 nibbles of payload and pairs them into 512 bytes, with the high nibble first.

Each data line carries its own 16-bit check value. The receiver runs four CRC16 engines side by side. Engine n takes only bit n of each payload nibble. After the payload it shifts in the 16 check bits that arrive on each line. A final stop sample ends the frame. The receiver then pulses a done flag and reports a per-lane CRC mismatch vector and a framing flag. It is back in start-search on the very next strobe, so blocks of a multi-block read may follow each other with any gap, including none. An abort input drops a partial block at once.

Top module: `sd_nib_rx`

## Requirements
- R1: While reset is active and after it is released, `byte_vld`, `blk_done`, `crc_err`, `frm_err` and `byte_out` are all zero until a block is received.
- R2: While searching, a block starts only on a strobe that samples `dat_in` equal to 4'h0. A strobe with any other value is ignored and produces no byte and no done pulse.
- R3: In a block, the 1024 strobes after the start strobe carry payload. The even-numbered nibble (0, 2, …) is bits 7:4 of a byte and the following odd nibble is bits 3:0. `byte_vld` is high for exactly one clock, in the cycle after the strobe that sampled the odd nibble, and `byte_out` then holds that byte. This gives 512 bytes per block.
- R4: Lane n (n = 0..3) computes a CRC16 with polynomial 0x1021 and an initial value of zero. The input is bit n of each payload nibble, processed most significant first in arrival order. The next 16 strobes deliver that lane's expected value on `dat_in[n]`, most significant bit first. At block end, `crc_err[n]` is 1 exactly when the two values differ.
- R5: The strobe after the 16 check strobes is the stop sample. `blk_done` is high for one clock in the cycle after it, and never earlier in the block. `frm_err` is 1 with it when the stop sample was not 4'hF. `crc_err` and `frm_err` are zero whenever `blk_done` is low.
- R6: Immediately after the stop sample the receiver is searching again, so a start on the next strobe begins a new block that is received correctly.
- R7: Without a strobe, no state advances. `dat_in` is ignored on cycles where `smp_en` is low, and `byte_vld` and `blk_done` never stay high past the single cycle after a strobe.
- R8: When `abort` is high on a clock edge, the receiver returns to search on that edge. The partial block is discarded, so it produces no further bytes and no done pulse, and the next start begins a fresh block with fresh CRC state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort | input | 1 | Drop any partial block and return to search |
| smp_en | input | 1 | One-cycle strobe: sample `dat_in` on this clock edge |
| dat_in | input | 4 | The four SD data lines, bit n is line n |
| byte_out | output | 8 | Assembled payload byte |
| byte_vld | output | 1 | One-cycle pulse: `byte_out` holds a new byte |
| blk_done | output | 1 | One-cycle pulse after the stop sample |
| crc_err | output | 4 | Per-lane CRC mismatch, valid with `blk_done` |
| frm_err | output | 1 | Stop sample not all ones, valid with `blk_done` |

## Verification
A nibble counter that has slipped shows up within two strobes, as a `byte_vld` on an even nibble or a byte with its halves swapped. The bench checks every byte position and every pulse on every block. A wrong CRC engine or receive shift register is invisible until the done pulse. There it appears as a `crc_err` bit that disagrees with the corruption the bench injected on exactly that lane. A phase machine that returns to search late, or that keeps a block alive after abort, misaligns the following block. That block then reports byte mismatches and CRC errors at its own done pulse, one block length later.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_DATA = 2'd1,
        RX_CRC  = 2'd2,
        RX_STOP = 2'd3
    } rx_phase_e;

    localparam int unsigned  LINE_CNT    = 4;
    localparam logic [15:0]  CRC16_POLY  = 16'h1021;
    localparam logic [3:0]   LINES_HIGH  = 4'hF;
    localparam logic [3:0]   LINES_LOW   = 4'h0;

endpackage

// File: rtl/sdrx_crc_lane.sv
module sdrx_crc_lane #(
    parameter int unsigned      CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = CRC_W'(16'h1021)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic calc_en,
    input  logic recv_en,
    input  logic bit_in,
    output logic mismatch
);

    typedef struct packed {
        logic [CRC_W-1:0] calc;
        logic [CRC_W-1:0] rcv;
    } lane_regs_t;

    lane_regs_t r_d, r_q;
    logic       fb;

    always_comb begin
        r_d = r_q;
        fb  = bit_in ^ r_q.calc[CRC_W-1];
        if (clr) begin
            r_d.calc = '0;
            r_d.rcv  = '0;
        end else if (calc_en) begin
            r_d.calc = {r_q.calc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end else if (recv_en) begin
            r_d.rcv = {r_q.rcv[CRC_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mismatch = (r_q.calc != r_q.rcv);

    // R4: received check bits move only during the check phase
    p_rcv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!recv_en && !clr) |=> $stable(r_q.rcv));

    // R7: the running CRC moves only on payload strobes
    p_calc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!calc_en && !clr) |=> $stable(r_q.calc));

    // R4: a cleared lane starts from zero
    p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (r_q.calc == '0 && r_q.rcv == '0));

endmodule

// File: rtl/sdrx_framer.sv
module sdrx_framer
    import sdrx_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = 512,
    parameter int unsigned CRC_W       = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort,
    input  logic                smp_en,
    input  logic [3:0]          dat_in,
    input  logic [LINE_CNT-1:0] lane_bad,
    output logic                lane_clr,
    output logic                lane_calc,
    output logic                lane_recv,
    output logic [7:0]          byte_out,
    output logic                byte_vld,
    output logic                blk_done,
    output logic [LINE_CNT-1:0] crc_err,
    output logic                frm_err
);

    localparam int unsigned NIB_N  = 2 * BLOCK_BYTES;
    localparam int unsigned CNT_MX = (NIB_N > CRC_W) ? NIB_N : CRC_W;
    localparam int unsigned CNT_W  = $clog2(CNT_MX);
    localparam logic [CNT_W-1:0] NIB_LAST = CNT_W'(NIB_N - 1);
    localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);

    typedef struct packed {
        rx_phase_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [3:0]          hi;
        logic [7:0]          byte_o;
        logic                vld;
        logic                done;
        logic [LINE_CNT-1:0] cerr;
        logic                ferr;
    } frm_regs_t;

    frm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.vld   = 1'b0;
        r_d.done  = 1'b0;
        r_d.cerr  = '0;
        r_d.ferr  = 1'b0;
        lane_clr  = 1'b0;
        lane_calc = 1'b0;
        lane_recv = 1'b0;
        if (abort) begin
            r_d.st  = RX_HUNT;
            r_d.cnt = '0;
        end else if (smp_en) begin
            case (r_q.st)
                RX_HUNT: begin
                    if (dat_in == LINES_LOW) begin
                        r_d.st   = RX_DATA;
                        r_d.cnt  = '0;
                        lane_clr = 1'b1;
                    end
                end
                RX_DATA: begin
                    lane_calc = 1'b1;
                    if (!r_q.cnt[0]) begin
                        r_d.hi = dat_in;
                    end else begin
                        r_d.byte_o = {r_q.hi, dat_in};
                        r_d.vld    = 1'b1;
                    end
                    if (r_q.cnt == NIB_LAST) begin
                        r_d.st  = RX_CRC;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                RX_CRC: begin
                    lane_recv = 1'b1;
                    if (r_q.cnt == CRC_LAST) begin
                        r_d.st  = RX_STOP;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: begin
                    r_d.done = 1'b1;
                    r_d.cerr = lane_bad;
                    r_d.ferr = (dat_in != LINES_HIGH);
                    r_d.st   = RX_HUNT;
                    r_d.cnt  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= RX_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_out = r_q.byte_o;
    assign byte_vld = r_q.vld;
    assign blk_done = r_q.done;
    assign crc_err  = r_q.cerr;
    assign frm_err  = r_q.ferr;

    // R7: a cycle without strobe or abort leaves phase and count alone
    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_en && !abort) |=> ($stable(r_q.st) && $stable(r_q.cnt)));

    // R8: abort lands in search with no output pulse
    p_abort_hunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (r_q.st == RX_HUNT && !r_q.done && !r_q.vld));

    // R5: status flags only accompany the done pulse
    p_flags_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.done |-> (r_q.cerr == '0 && !r_q.ferr));

    // R5: done only follows a strobe in the stop phase
    p_done_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> ($past(r_q.st) == RX_STOP && $past(smp_en)));

    // R3: bytes only come out of the payload phase
    p_vld_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld |-> ($past(r_q.st) == RX_DATA && $past(r_q.cnt[0])));

    // R3: payload count stays inside the block
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RX_DATA) |-> (r_q.cnt <= NIB_LAST));

    // R6: done coincides with being back in search
    p_hunt_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.st == RX_HUNT));

endmodule

// File: rtl/sd_nib_rx.sv
module sd_nib_rx
    import sdrx_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = 512,
    parameter int unsigned CRC_W       = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       smp_en,
    input  logic [3:0] dat_in,
    output logic [7:0] byte_out,
    output logic       byte_vld,
    output logic       blk_done,
    output logic [3:0] crc_err,
    output logic       frm_err
);

    logic                lane_clr;
    logic                lane_calc;
    logic                lane_recv;
    logic [LINE_CNT-1:0] lane_bad;

    sdrx_framer #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .CRC_W       (CRC_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .smp_en    (smp_en),
        .dat_in    (dat_in),
        .lane_bad  (lane_bad),
        .lane_clr  (lane_clr),
        .lane_calc (lane_calc),
        .lane_recv (lane_recv),
        .byte_out  (byte_out),
        .byte_vld  (byte_vld),
        .blk_done  (blk_done),
        .crc_err   (crc_err),
        .frm_err   (frm_err)
    );

    for (genvar g = 0; g < LINE_CNT; g++) begin : g_lane
        sdrx_crc_lane #(
            .CRC_W (CRC_W),
            .POLY  (CRC_W'(CRC16_POLY))
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (lane_clr),
            .calc_en  (lane_calc),
            .recv_en  (lane_recv),
            .bit_in   (dat_in[g]),
            .mismatch (lane_bad[g])
        );
    end

endmodule

// File: tb/sd_nib_rx_tb.sv
module sd_nib_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 512;
    localparam int NIB        = 2 * NBYTES;
    localparam int WD_CYC     = 150000;

    // fields: kind[23:22] seed[21:14] crc_flip_mask[13:10] stop[9:6] gap[5:2] stall[1:0]
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [0:NVEC-1] = '{
        {2'd0, 8'h11, 4'h0, 4'hF, 4'd15, 2'd0},
        {2'd1, 8'h00, 4'h0, 4'hF, 4'd0,  2'd0},
        {2'd2, 8'hA5, 4'h5, 4'hF, 4'd2,  2'd1},
        {2'd1, 8'hFF, 4'h0, 4'h7, 4'd4,  2'd0},
        {2'd0, 8'h3C, 4'hA, 4'hF, 4'd15, 2'd3},
        {2'd2, 8'h00, 4'hF, 4'h0, 4'd1,  2'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       abort = 1'b0;
    logic       smp_en = 1'b0;
    logic [3:0] dat_in = 4'hF;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       blk_done;
    logic [3:0] crc_err;
    logic       frm_err;

    int errs = 0;
    int nchk = 0;
    int stray = 0;

    logic       s_vld, s_done, s_ferr;
    logic [7:0] s_byte;
    logic [3:0] s_cerr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_nib_rx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .smp_en   (smp_en),
        .dat_in   (dat_in),
        .byte_out (byte_out),
        .byte_vld (byte_vld),
        .blk_done (blk_done),
        .crc_err  (crc_err),
        .frm_err  (frm_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [1:0] k, input logic [7:0] s,
                                           input int i);
        case (k)
            2'd0:    return s + 8'(i);
            2'd1:    return s;
            default: return (8'(i * 7) + s) ^ 8'(i >> 3);
        endcase
    endfunction

    // one strobe, snapshot of outputs after the edge, then idle cycles
    task automatic strobe(input logic [3:0] d, input int stall);
        dat_in = d;
        smp_en = 1'b1;
        @(negedge clk);
        s_vld  = byte_vld;
        s_byte = byte_out;
        s_done = blk_done;
        s_cerr = crc_err;
        s_ferr = frm_err;
        smp_en = 1'b0;
        for (int c = 0; c < stall; c++) begin
            @(negedge clk);
            if (byte_vld || blk_done) stray++;
        end
    endtask

    task automatic send_block(input logic [1:0] kind, input logic [7:0] seed,
                              input logic [3:0] cmask, input logic [3:0] stop,
                              input int stall, input string tag);
        logic [15:0] ecrc [4];
        logic [7:0]  b;
        logic [3:0]  nib;
        int bad = 0;
        int nv = 0;
        int dpre = 0;
        for (int l = 0; l < 4; l++) ecrc[l] = 16'h0;
        strobe(4'h0, stall);
        if (s_vld || s_done) dpre++;
        for (int i = 0; i < NIB; i++) begin
            b   = byte_of(kind, seed, i / 2);
            nib = (i % 2 == 0) ? b[7:4] : b[3:0];
            for (int l = 0; l < 4; l++) begin
                logic fb;
                fb = nib[l] ^ ecrc[l][15];
                ecrc[l] = {ecrc[l][14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
            end
            strobe(nib, stall);
            if (i % 2 == 1) begin
                if (!s_vld || s_byte != b) bad++;
            end else if (s_vld) begin
                bad++;
            end
            if (s_vld) nv++;
            if (s_done) dpre++;
        end
        for (int k = 0; k < 16; k++) begin
            for (int l = 0; l < 4; l++)
                nib[l] = ecrc[l][15 - k] ^ (cmask[l] && k == 15);
            strobe(nib, stall);
            if (s_vld || s_done) dpre++;
        end
        strobe(stop, stall);
        chk(bad == 0 && nv == NBYTES, "R3", {tag, " byte errors"}, bad, 0);
        chk(dpre == 0 && s_done, "R5", {tag, " done only after stop"}, dpre, 0);
        chk(s_cerr == cmask, "R4", {tag, " crc_err per lane"}, s_cerr, cmask);
        chk(s_ferr == (stop != 4'hF), "R5", {tag, " frm_err"}, s_ferr, stop != 4'hF);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        int prev_gap = 15;
        repeat (3) @(negedge clk);
        // R1: outputs quiet through and after reset
        chk(!byte_vld && !blk_done && crc_err == 0 && !frm_err && byte_out == 0,
            "R1", "outputs during reset", {byte_vld, blk_done, crc_err, frm_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!byte_vld && !blk_done && byte_out == 0, "R1", "outputs after reset",
            {byte_out, byte_vld, blk_done}, 0);

        // R2: non-zero samples while searching start nothing
        begin
            int seen = 0;
            logic [3:0] pat [6] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'hE, 4'hF};
            for (int r = 0; r < 4; r++)
                for (int p = 0; p < 6; p++) begin
                    strobe(pat[p], 0);
                    if (s_vld || s_done) seen++;
                end
            chk(seen == 0, "R2", "pulses from non-start samples", seen, 0);
        end

        // table of blocks
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] e;
            string t;
            e = VEC[v];
            t = $sformatf("vec%0d", v);
            send_block(e[23:22], e[21:14], e[13:10], e[9:6], int'(e[1:0]), t);
            if (prev_gap == 0)
                chk(s_done && s_cerr == e[13:10], "R6", {t, " back-to-back block"},
                    s_cerr, e[13:10]);
            for (int g = 0; g < int'(e[5:2]); g++) strobe(4'hF, int'(e[1:0]));
            prev_gap = int'(e[5:2]);
        end
        chk(stray == 0, "R7", "pulses on cycles without strobe", stray, 0);

        // R7: low lines without strobe must not start a block
        begin
            int seen = 0;
            dat_in = 4'h0;
            smp_en = 1'b0;
            repeat (20) begin
                @(negedge clk);
                if (byte_vld || blk_done) seen++;
            end
            for (int p = 0; p < 4; p++) begin
                strobe(4'h5, 0);
                if (s_vld) seen++;
            end
            chk(seen == 0, "R7", "start seen without strobe", seen, 0);
        end

        // R8: abort in mid-payload, then a clean block
        begin
            int seen = 0;
            strobe(4'h0, 0);
            for (int i = 0; i < 300; i++) strobe(4'(i), 0);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            if (byte_vld || blk_done) seen++;
            for (int i = 0; i < 30; i++) begin
                strobe(4'hF, 0);
                if (s_vld || s_done) seen++;
            end
            chk(seen == 0, "R8", "pulses after abort", seen, 0);
            send_block(2'd2, 8'h5A, 4'h0, 4'hF, 0, "R8 block after abort");
        end

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

endmodule